// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from reset to a usable state. After reset it raises the clock-enable pin and waits a programmable stabilisation period. It then closes all banks, issues a programmable number of auto-refresh commands and writes the mode register. Each command is held off until the minimum spacing required after the previous one has elapsed. An internal busy flag covers that spacing, and no command leaves while the flag is high.

Once the mode register is written and its recovery time has passed, the block starts a free-running refresh interval timer and raises its ready output. The timer reload is the ideal per-row refresh period less a safety margin: with a 64 ms window, 4096 rows and a 150 MHz clock the reload is 2323. Each time the timer expires, the block pulses a refresh request for one cycle, which a downstream controller turns into an auto-refresh. Reads, writes and arbitration belong to that controller.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and in the first sampled cycle of reset, CKE is low, the command pins show NOP (CS#=0, RAS#=1, CAS#=1, WE#=1), and ready, busy and refresh request are all low.
- R2: CKE goes high on the first clock edge after reset is released and stays high. The precharge-all command appears exactly PWRUP_CYCLES cycles after CKE rises.
- R3: Commands are encoded on {CS#,RAS#,CAS#,WE#} as NOP 0111, precharge-all 0010, auto-refresh 0001 and mode-register load 0000. Precharge-all drives address bit 10 high with every other address and bank bit low. Auto-refresh drives address and bank zero.
- R4: Exactly one precharge-all, then exactly AREF_COUNT auto-refreshes, then one mode-register load are issued, in that order. AREF_COUNT must be at least 2, and the values 4 and 8 are both exercised.
- R5: The command after the precharge-all comes exactly T_RP (3) cycles later.
- R6: The command after each auto-refresh comes exactly T_RFC (11) cycles later.
- R7: The mode-register load drives bank 0 and address 0x231: burst-length code 001 in bits 2..0, sequential type (bit 3 = 0), CAS latency 3 in bits 6..4, standard mode (bits 8..7 = 00) and single-location writes (bit 9 = 1). Ready rises exactly T_MRD (2) cycles after this command.
- R8: For N-1 cycles after a command that needs spacing N, and for PWRUP_CYCLES-1 cycles after CKE rises, busy is high. Busy is low otherwise, and no command is issued while it is high.
- R9: Refresh request is a one-cycle pulse. The first pulse comes RELOAD+1 cycles after ready rises, and later pulses follow every RELOAD+1 cycles. RELOAD is (window / rows × clock in MHz) − 20, which is 2323 for 64 ms, 4096 rows and 150 MHz.
- R10: Once ready is high it stays high, and the command pins show only NOP. Refresh request never pulses while ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_busy | output | 1 | High while command spacing is still running |
| init_done | output | 1 | Initialization complete, refresh timer running |
| refresh_req | output | 1 | One-cycle pulse on each refresh interval expiry |

## Verification
Two of the block's actions share a cycle. When the refresh timer expires, it raises the request pulse and reloads itself on the same edge. Likewise, the end of mode-register recovery both raises ready and starts the timer. The bench lets two instances, one with four and one with eight start-up refreshes, run through several refresh periods. It measures every gap between ready and each pulse, which must be exactly RELOAD+1 cycles. A slip of one cycle at reload, or a pulse lasting two cycles, shows up as a wrong interval.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS  = 4'b0000,
      CMD_AREF = 4'b0001,
      CMD_PRE  = 4'b0010,
      CMD_NOP  = 4'b0111
   } cmd_t;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_PRE,
      ST_AREF,
      ST_MRS,
      ST_ARM,
      ST_RUN
   } seq_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic [2:0] burst_code(input int len);
      case (len)
         1:       return 3'b000;
         2:       return 3'b001;
         4:       return 3'b010;
         8:       return 3'b011;
         default: return 3'b111;
      endcase
   endfunction

   // Mode word: [2:0] burst length, [3] interleave, [6:4] CAS latency,
   // [8:7] operating mode, [9] single-location writes
   function automatic logic [15:0] mode_word(input int len, input int cas,
                                             input bit interleave,
                                             input bit single_wr);
      logic [15:0] w;
      w       = '0;
      w[2:0]  = burst_code(len);
      w[3]    = interleave;
      w[6:4]  = 3'(cas);
      w[8:7]  = 2'b00;
      w[9]    = single_wr;
      return w;
   endfunction

endpackage

// File: rtl/sdi_gap_timer.sv
module sdi_gap_timer #(
   parameter int MAX_GAP = 64,
   localparam int TW = (MAX_GAP > 1) ? $clog2(MAX_GAP) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          busy
);

   if (MAX_GAP < 1) begin : g_bad_gap
      $error("sdi_gap_timer: MAX_GAP must be at least 1");
   end

   if (MAX_GAP == 1) begin : g_no_count
      // Every spacing is one cycle: nothing to hold off
      assign busy = 1'b0;
      logic unused_in;
      assign unused_in = load ^ (^load_val);
   end else begin : g_count
      logic [TW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (load) begin
            cnt_q <= load_val;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign busy = (cnt_q != '0);

      assert_busy_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
   end

endmodule

// File: rtl/sdi_refresh_timer.sv
module sdi_refresh_timer #(
   parameter int RELOAD = 2323,
   localparam int RW = $clog2(RELOAD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic req
);

   if (RELOAD < 1) begin : g_bad_reload
      $error("sdi_refresh_timer: RELOAD must be at least 1");
   end

   logic [RW-1:0] cnt_q;
   logic          run_q;
   logic          req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         req_q <= 1'b0;
      end else if (start) begin
         cnt_q <= RW'(RELOAD);
         run_q <= 1'b1;
         req_q <= 1'b0;
      end else if (run_q) begin
         if (cnt_q == '0) begin
            cnt_q <= RW'(RELOAD);
            req_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
            req_q <= 1'b0;
         end
      end else begin
         req_q <= 1'b0;
      end
   end

   assign req = req_q;

   assert_req_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);

   assert_reload_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !start && cnt_q == '0) |=> (req && cnt_q == RW'(RELOAD)));

   assert_req_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> run_q);

endmodule

// File: rtl/sdi_pin_driver.sv
module sdi_pin_driver
   import sdi_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int BA_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_on,
   input  logic              issue,
   input  cmd_t              cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BA_W-1:0]   ba,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0] sd_addr
);

   cmd_t              cmd_q;
   logic              cke_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BA_W-1:0]   ba_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke_q  <= 1'b0;
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
         ba_q   <= '0;
      end else begin
         if (cke_on) begin
            cke_q <= 1'b1;
         end
         if (issue) begin
            cmd_q  <= cmd;
            addr_q <= addr;
            ba_q   <= ba;
         end else begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            ba_q   <= '0;
         end
      end
   end

   assign sd_cke   = cke_q;
   assign sd_cs_n  = cmd_q[3];
   assign sd_ras_n = cmd_q[2];
   assign sd_cas_n = cmd_q[1];
   assign sd_we_n  = cmd_q[0];
   assign sd_ba    = ba_q;
   assign sd_addr  = addr_q;

   assert_pre_a10_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010) |-> sd_addr[10]);

   assert_cmd_after_cke_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111) |-> sd_cke);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdi_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int BA_W          = 2,
   parameter int PWRUP_CYCLES  = 64,
   parameter int AREF_COUNT    = 8,
   parameter int T_RP          = 3,
   parameter int T_RFC         = 11,
   parameter int T_MRD         = 2,
   parameter int CLK_MHZ       = 150,
   parameter int REF_WINDOW_US = 64000,
   parameter int REF_ROWS      = 4096,
   parameter int REF_MARGIN    = 20,
   parameter int BURST_LEN     = 2,
   parameter int CAS_LAT       = 3,
   parameter bit WRITE_SINGLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              init_busy,
   output logic              init_done,
   output logic              refresh_req
);

   localparam int MAX_GAP   = max_of(max_of(PWRUP_CYCLES, T_RP), max_of(T_RFC, T_MRD));
   localparam int TW        = (MAX_GAP > 1) ? $clog2(MAX_GAP) : 1;
   localparam int AW        = $clog2(AREF_COUNT + 1);
   localparam int ROW_NS    = (REF_WINDOW_US * 1000) / REF_ROWS;
   localparam int RELOAD    = (ROW_NS * CLK_MHZ) / 1000 - REF_MARGIN;
   localparam logic [15:0] MODE_FULL = mode_word(BURST_LEN, CAS_LAT, 1'b0, WRITE_SINGLE);
   localparam logic [ADDR_W-1:0] MODE_VAL = MODE_FULL[ADDR_W-1:0];

   if (AREF_COUNT < 2) begin : g_bad_aref
      $error("sdram_init_seq: AREF_COUNT must be at least 2");
   end
   if (ADDR_W < 11) begin : g_bad_addr
      $error("sdram_init_seq: ADDR_W must reach bit 10");
   end
   if (PWRUP_CYCLES < 1 || T_RP < 1 || T_RFC < 1 || T_MRD < 1) begin : g_bad_gap
      $error("sdram_init_seq: every spacing must be at least one cycle");
   end
   if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cas
      $error("sdram_init_seq: CAS_LAT must be 2 or 3");
   end
   if (BURST_LEN != 1 && BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
      $error("sdram_init_seq: BURST_LEN must be 1, 2, 4 or 8");
   end
   if (RELOAD < 1) begin : g_bad_reload
      $error("sdram_init_seq: refresh reload underflows");
   end

   seq_t              st_q, st_d;
   logic [AW-1:0]     aref_q, aref_d;
   logic              ready_q, ready_d;
   logic              issue;
   cmd_t              cmd_d;
   logic [ADDR_W-1:0] addr_d;
   logic [BA_W-1:0]   ba_d;
   logic              t_load;
   logic [TW-1:0]     t_val;
   logic              t_busy;
   logic              cke_on;
   logic              ref_start;
   logic              unused_mode;

   assign unused_mode = ^MODE_FULL;

   always_comb begin
      st_d      = st_q;
      aref_d    = aref_q;
      ready_d   = ready_q;
      issue     = 1'b0;
      cmd_d     = CMD_NOP;
      addr_d    = '0;
      ba_d      = '0;
      t_load    = 1'b0;
      t_val     = '0;
      cke_on    = 1'b0;
      ref_start = 1'b0;
      case (st_q)
         ST_BOOT: begin
            cke_on = 1'b1;
            t_load = 1'b1;
            t_val  = TW'(PWRUP_CYCLES - 1);
            st_d   = ST_PRE;
         end
         ST_PRE: begin
            if (!t_busy) begin
               issue      = 1'b1;
               cmd_d      = CMD_PRE;
               addr_d[10] = 1'b1;
               t_load     = 1'b1;
               t_val      = TW'(T_RP - 1);
               st_d       = ST_AREF;
            end
         end
         ST_AREF: begin
            if (!t_busy) begin
               issue  = 1'b1;
               cmd_d  = CMD_AREF;
               t_load = 1'b1;
               t_val  = TW'(T_RFC - 1);
               aref_d = aref_q + 1'b1;
               if (aref_q == AW'(AREF_COUNT - 1)) begin
                  st_d = ST_MRS;
               end
            end
         end
         ST_MRS: begin
            if (!t_busy) begin
               issue  = 1'b1;
               cmd_d  = CMD_MRS;
               addr_d = MODE_VAL;
               t_load = 1'b1;
               t_val  = TW'(T_MRD - 1);
               st_d   = ST_ARM;
            end
         end
         ST_ARM: begin
            if (!t_busy) begin
               ref_start = 1'b1;
               ready_d   = 1'b1;
               st_d      = ST_RUN;
            end
         end
         default: begin
            st_d = ST_RUN;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_BOOT;
         aref_q  <= '0;
         ready_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         aref_q  <= aref_d;
         ready_q <= ready_d;
      end
   end

   sdi_gap_timer #(.MAX_GAP(MAX_GAP)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .busy     (t_busy)
   );

   sdi_refresh_timer #(.RELOAD(RELOAD)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ref_start),
      .req   (refresh_req)
   );

   sdi_pin_driver #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke_on   (cke_on),
      .issue    (issue),
      .cmd      (cmd_d),
      .addr     (addr_d),
      .ba       (ba_d),
      .sd_cke   (sd_cke),
      .sd_cs_n  (sd_cs_n),
      .sd_ras_n (sd_ras_n),
      .sd_cas_n (sd_cas_n),
      .sd_we_n  (sd_we_n),
      .sd_ba    (sd_ba),
      .sd_addr  (sd_addr)
   );

   assign init_busy = t_busy;
   assign init_done = ready_q;

   assert_no_issue_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !t_busy);

   assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sd_cke |=> sd_cke);

   assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_quiet_after_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));

   assert_req_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> init_done);

   assert_aref_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MRS) |-> (aref_q == AW'(AREF_COUNT)));

   assert_mode_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000) |-> (sd_ba == '0));

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

   localparam int PWRUP  = 64;
   localparam int T_RP   = 3;
   localparam int T_RFC  = 11;
   localparam int T_MRD  = 2;
   localparam int ROW_NS = 64000 * 1000 / 4096;
   localparam int RELOAD = ROW_NS * 150 / 1000 - 20;
   localparam int WD     = 20000;

   typedef struct {
      logic [3:0]  cmd;
      logic [11:0] addr;
      logic [1:0]  ba;
      int          gap;
      int          after;
      string       req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic        cke [2];
   logic [3:0]  pins [2];
   logic [1:0]  ba [2];
   logic [11:0] addr [2];
   logic        busy [2];
   logic        done [2];
   logic        req [2];

   sdram_init_seq #(.PWRUP_CYCLES(PWRUP), .AREF_COUNT(8)) dut (
      .clk(clk), .rst_n(rst_n), .sd_cke(cke[0]),
      .sd_cs_n(pins[0][3]), .sd_ras_n(pins[0][2]), .sd_cas_n(pins[0][1]), .sd_we_n(pins[0][0]),
      .sd_ba(ba[0]), .sd_addr(addr[0]), .init_busy(busy[0]), .init_done(done[0]),
      .refresh_req(req[0]));

   sdram_init_seq #(.PWRUP_CYCLES(PWRUP), .AREF_COUNT(4)) dut4 (
      .clk(clk), .rst_n(rst_n), .sd_cke(cke[1]),
      .sd_cs_n(pins[1][3]), .sd_ras_n(pins[1][2]), .sd_cas_n(pins[1][1]), .sd_we_n(pins[1][0]),
      .sd_ba(ba[1]), .sd_addr(addr[1]), .init_busy(busy[1]), .init_done(done[1]),
      .refresh_req(req[1]));

   exp_t sbq [2][$];
   int   n_checks = 0;
   int   n_err = 0;
   bit   cke_seen [2];
   bit   rdy_seen [2];
   int   last_t [2];
   int   next_gap [2];
   int   since [2];
   int   last_req [2];
   int   req_cnt [2];

   task automatic chk(input string r, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   task automatic push(input int i, input logic [3:0] c, input logic [11:0] a,
                       input int g, input int aft, input string r);
      exp_t e;
      e.cmd = c; e.addr = a; e.ba = 2'b00; e.gap = g; e.after = aft; e.req = r;
      sbq[i].push_back(e);
   endtask

   // Driver: expected init sequence (R3..R7)
   task automatic plan_init(input int i, input int n_aref);
      push(i, 4'b0010, 12'h400, PWRUP, T_RP, "R2/R3");
      for (int k = 0; k < n_aref; k++)
         push(i, 4'b0001, 12'h000, (k == 0) ? T_RP : T_RFC, T_RFC, (k == 0) ? "R5/R4" : "R6/R4");
      push(i, 4'b0000, 12'h231, T_RFC, T_MRD, "R7/R6");
   endtask

   task automatic observe(input int i);
      exp_t e;
      if (!cke_seen[i] && cke[i]) begin
         cke_seen[i] = 1'b1;
         chk("R2", "cke rise cycle", cyc, 1);
         last_t[i] = cyc; next_gap[i] = PWRUP; since[i] = 0;
      end
      if (pins[i] != 4'b0111) begin
         if (sbq[i].size() == 0) begin
            chk("R10", "unexpected command", pins[i], 4'b0111);
         end else begin
            e = sbq[i].pop_front();
            chk(e.req, "command code", pins[i], e.cmd);
            chk(e.req, "address", addr[i], e.addr);
            chk(e.req, "bank", ba[i], e.ba);
            chk(e.req, "spacing", cyc - last_t[i], e.gap);
            last_t[i] = cyc; next_gap[i] = e.after; since[i] = 0;
         end
      end
      if (!rdy_seen[i] && done[i]) begin
         rdy_seen[i] = 1'b1;
         chk("R7", "ready after mode load", cyc - last_t[i], T_MRD);
         chk("R4", "commands left", sbq[i].size(), 0);
         last_req[i] = cyc;
      end
      if (rdy_seen[i] && !done[i]) chk("R10", "ready dropped", 0, 1);
      if (req[i]) begin
         if (!rdy_seen[i]) chk("R10", "request before ready", 1, 0);
         else chk("R9", "refresh interval", cyc - last_req[i], RELOAD + 1);
         last_req[i] = cyc;
         req_cnt[i]++;
      end
      if (cke_seen[i] && !rdy_seen[i]) begin
         chk("R8", "busy", busy[i], (since[i] < next_gap[i] - 1) ? 1 : 0);
         since[i]++;
      end else if (rdy_seen[i] && busy[i]) begin
         chk("R8", "busy after ready", 1, 0);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 2; i++) observe(i);
      end
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         cke_seen[i] = 0; rdy_seen[i] = 0; last_t[i] = 0; next_gap[i] = 0;
         since[i] = 0; last_req[i] = 0; req_cnt[i] = 0;
      end
      plan_init(0, 8);
      plan_init(1, 4);
      repeat (4) @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         chk("R1", "cke in reset", cke[i], 0);
         chk("R1", "pins in reset", pins[i], 4'b0111);
         chk("R1", "ready in reset", done[i], 0);
         chk("R1", "busy in reset", busy[i], 0);
         chk("R1", "request in reset", req[i], 0);
      end
      cyc = 0;
      rst_n = 1'b1;
      while (!(req_cnt[0] >= 3 && req_cnt[1] >= 3) && cyc < WD) @(negedge clk);
      if (cyc >= WD) chk("R9", "watchdog expired", cyc, WD - 1);
      for (int i = 0; i < 2; i++) begin
         chk("R4", "scoreboard drained", sbq[i].size(), 0);
         chk("R9", "pulses seen", req_cnt[i] >= 3, 1);
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule